// File: doc/BRIEF.md
# Bus Cycle Termination Controller

This controller runs on the master side of an asynchronous bus. It owns the address strobe and decides how each bus cycle ends. Four active-low responses come back from the slave side: a two-bit data-size acknowledge, an autovector acknowledge, a bus error and a halt. From their relative timing the controller produces one of four results: normal, halt, bus error or retry. The result is reported as a one-clock termination strobe together with a two-bit code.

All responses are assumed to change on the rising clock edge. They are captured on the falling edge, so responses that assert together always land in the same sample. The termination logic acts on the next rising edge.

A built-in bus monitor handles slaves that never answer. When no acknowledge, autovector or external bus error arrives within a programmable number of clocks, the monitor raises an internal bus error. After a halt termination the controller holds further cycles off and raises a single-step flag. After a retry it reissues the same cycle by itself once the bus is quiet again.

Top module: `bus_term_ctrl`

## Requirements
- R1: An acknowledge (either size bit or the autovector) with bus error and halt negated ends the cycle with code 00 (normal). The result is committed one sample after the acknowledge, so that a late error can still be seen.
- R2: Halt asserted before or together with the acknowledge, with bus error negated, ends the cycle with code 01. The single-step flag is then raised. No new strobe is driven until halt negates.
- R3: Bus error without halt ends the cycle with code 10 in three cases: it arrives instead of the acknowledge, it arrives with or before the acknowledge, or it arrives in the first sample after the acknowledge.
- R4: Bus error together with halt ends the cycle with code 11 (retry) in all of these cases: in place of the acknowledge, with it, before it, or in the sample after it. Once bus error, halt and the acknowledges have all negated, the strobe is reasserted for the same cycle without a new request.
- R5: With a nonzero monitor limit N and no response, a code-10 termination is observed N+1 clocks after the strobe is first observed asserted.
- R6: A monitor limit of zero disables the timeout. An acknowledge, autovector or external bus error seen before expiry cancels the timeout for that cycle.
- R7: The termination strobe is high for exactly one clock. The code is valid in that clock, and the address strobe is negated in the same clock.
- R8: A cycle never starts while an acknowledge or bus error is still sampled asserted. A pending request waits until they negate.
- R9: The autovector acknowledge terminates a cycle in the same way as the size acknowledge.
- R10: Synchronous reset leaves the strobe negated, the termination strobe low and the single-step flag low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; responses captured on the falling edge, logic on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cyc_req | input | 1 | One-clock pulse requesting a bus cycle |
| tmo_limit | input | 8 | Monitor period in clocks, taken when the strobe asserts; 0 disables |
| dsz_ack_n | input | 2 | Data-size acknowledge, active low, either bit acknowledges |
| avec_ack_n | input | 1 | Autovector acknowledge, active low |
| berr_in_n | input | 1 | External bus error, active low |
| halt_in_n | input | 1 | Halt, active low |
| as_n | output | 1 | Address strobe, active low, registered |
| term_stb | output | 1 | One-clock termination strobe |
| term_code | output | 2 | 00 normal, 01 halt, 10 bus error, 11 retry |
| step_hold | output | 1 | High while held after a halt termination |

## Verification
The bench builds the block with its default two-bit acknowledge and eight-bit monitor counter. It drives the monitor limit through 0 and 1 to 12. This puts every short timeout latency within reach, along with the disabled case. With the monitor off, it sweeps the first-assertion clock of the acknowledge, bus error and halt over a small window, including halt before the strobe. That sweep covers every ordering of the three signals, including late error and late retry. The expected code comes from an arithmetic model of the ordering rules. Directed sequences cover the halt hold, the retry reissue, the wait for stale responses to clear and the autovector path.

// File: rtl/btc_pkg.sv
package btc_pkg;

  typedef enum logic [1:0] {
    TERM_NORMAL = 2'b00,
    TERM_HALT   = 2'b01,
    TERM_BERR   = 2'b10,
    TERM_RETRY  = 2'b11
  } term_code_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ACTIVE,
    ST_LATE,
    ST_HOLD,
    ST_RWAIT
  } ctl_state_t;

endpackage

// File: rtl/btc_sampler.sv
module btc_sampler #(
  parameter int ACK_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ACK_W-1:0] dsz_ack_n,
  input  logic             avec_ack_n,
  input  logic             berr_in_n,
  input  logic             halt_in_n,
  output logic             s_ack,
  output logic             s_avec,
  output logic             s_berr,
  output logic             s_halt
);

  logic [ACK_W-1:0] ack_hit;

  // one decode per acknowledge lane
  for (genvar i = 0; i < ACK_W; i++) begin : g_lane
    assign ack_hit[i] = ~dsz_ack_n[i];
  end

  // falling-edge capture so simultaneous changes share one sample
  always_ff @(negedge clk) begin
    if (rst) begin
      s_ack  <= 1'b0;
      s_avec <= 1'b0;
      s_berr <= 1'b0;
      s_halt <= 1'b0;
    end else begin
      s_ack  <= |ack_hit;
      s_avec <= ~avec_ack_n;
      s_berr <= ~berr_in_n;
      s_halt <= ~halt_in_n;
    end
  end

endmodule

// File: rtl/btc_monitor.sv
module btc_monitor #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             active,
  input  logic [CNT_W-1:0] limit,
  input  logic             s_ack,
  input  logic             s_avec,
  input  logic             s_berr,
  output logic             fire
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt;
  logic             armed;
  logic             answered;

  assign answered = s_ack | s_avec | s_berr;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      armed <= 1'b0;
      fire  <= 1'b0;
    end else begin
      fire <= 1'b0;
      if (start) begin
        cnt   <= limit;
        armed <= (limit != '0);
      end else if (armed) begin
        if (!active || answered) begin
          armed <= 1'b0;
        end else if (cnt == ONE) begin
          armed <= 1'b0;
          fire  <= 1'b1;
        end else begin
          cnt <= cnt - ONE;
        end
      end
    end
  end

  // R6
  fire_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    fire |-> $past(active && !s_ack && !s_avec && !s_berr));

endmodule

// File: rtl/btc_fsm.sv
module btc_fsm
  import btc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       cyc_req,
  input  logic       s_ack,
  input  logic       s_avec,
  input  logic       s_berr,
  input  logic       s_halt,
  input  logic       tmo,
  output logic       start,
  output logic       active,
  output logic       as_n,
  output logic       term_stb,
  output logic [1:0] term_code,
  output logic       step_hold
);

  ctl_state_t state, nxt;
  term_code_t code;
  logic       fin;
  logic       pend;
  logic       resp;
  logic       err_eff;
  logic       quiet;

  assign resp    = s_ack | s_avec;
  assign err_eff = s_berr | tmo;
  assign quiet   = !s_ack && !s_avec && !s_berr;
  assign active  = (state == ST_ACTIVE);

  always_comb begin
    nxt   = state;
    fin   = 1'b0;
    start = 1'b0;
    code  = TERM_NORMAL;
    unique case (state)
      ST_IDLE: begin
        if ((pend || cyc_req) && quiet) begin
          start = 1'b1;
          nxt   = ST_ACTIVE;
        end
      end
      ST_ACTIVE: begin
        if (err_eff) begin
          fin  = 1'b1;
          code = s_halt ? TERM_RETRY : TERM_BERR;
        end else if (resp) begin
          if (s_halt) begin
            fin  = 1'b1;
            code = TERM_HALT;
          end else begin
            nxt = ST_LATE;
          end
        end
      end
      ST_LATE: begin
        fin = 1'b1;
        if (err_eff) code = s_halt ? TERM_RETRY : TERM_BERR;
        else         code = TERM_NORMAL;
      end
      ST_HOLD: begin
        if (!s_halt) nxt = ST_IDLE;
      end
      ST_RWAIT: begin
        if (quiet && !s_halt) begin
          start = 1'b1;
          nxt   = ST_ACTIVE;
        end
      end
      default: nxt = ST_IDLE;
    endcase
    if (fin) begin
      unique case (code)
        TERM_HALT:  nxt = ST_HOLD;
        TERM_RETRY: nxt = ST_RWAIT;
        default:    nxt = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      as_n      <= 1'b1;
      term_stb  <= 1'b0;
      term_code <= TERM_NORMAL;
      step_hold <= 1'b0;
      pend      <= 1'b0;
    end else begin
      state     <= nxt;
      term_stb  <= fin;
      step_hold <= (nxt == ST_HOLD);
      if (fin) term_code <= code;
      if (start)    as_n <= 1'b0;
      else if (fin) as_n <= 1'b1;
      if (start && state == ST_IDLE) pend <= 1'b0;
      else if (cyc_req)              pend <= 1'b1;
    end
  end

  // R7
  term_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    term_stb |=> !term_stb);

  // R7
  strobe_release_chk: assert property (@(posedge clk) disable iff (rst)
    term_stb |-> as_n);

  // R8
  clean_start_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(as_n) |-> $past(!s_ack && !s_berr));

  // R2
  hold_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    step_hold |-> as_n);

  // R2
  halt_code_chk: assert property (@(posedge clk) disable iff (rst)
    (term_stb && term_code == TERM_HALT) |-> $past(s_halt && !s_berr));

endmodule

// File: rtl/bus_term_ctrl.sv
module bus_term_ctrl #(
  parameter int ACK_W = 2,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cyc_req,
  input  logic [CNT_W-1:0] tmo_limit,
  input  logic [ACK_W-1:0] dsz_ack_n,
  input  logic             avec_ack_n,
  input  logic             berr_in_n,
  input  logic             halt_in_n,
  output logic             as_n,
  output logic             term_stb,
  output logic [1:0]       term_code,
  output logic             step_hold
);

  logic s_ack, s_avec, s_berr, s_halt;
  logic tmo, start, active;

  btc_sampler #(.ACK_W(ACK_W)) u_smp (
    .clk        (clk),
    .rst        (rst),
    .dsz_ack_n  (dsz_ack_n),
    .avec_ack_n (avec_ack_n),
    .berr_in_n  (berr_in_n),
    .halt_in_n  (halt_in_n),
    .s_ack      (s_ack),
    .s_avec     (s_avec),
    .s_berr     (s_berr),
    .s_halt     (s_halt)
  );

  btc_monitor #(.CNT_W(CNT_W)) u_mon (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .active (active),
    .limit  (tmo_limit),
    .s_ack  (s_ack),
    .s_avec (s_avec),
    .s_berr (s_berr),
    .fire   (tmo)
  );

  btc_fsm u_fsm (
    .clk       (clk),
    .rst       (rst),
    .cyc_req   (cyc_req),
    .s_ack     (s_ack),
    .s_avec    (s_avec),
    .s_berr    (s_berr),
    .s_halt    (s_halt),
    .tmo       (tmo),
    .start     (start),
    .active    (active),
    .as_n      (as_n),
    .term_stb  (term_stb),
    .term_code (term_code),
    .step_hold (step_hold)
  );

endmodule

// File: tb/bus_term_ctrl_tb.sv
module bus_term_ctrl_tb;
  timeunit 1ns;
  timeprecision 1ps;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cyc_req = 1'b0;
  logic [7:0] tmo_limit = 8'd0;
  logic [1:0] dsz_ack_n = 2'b11;
  logic       avec_ack_n = 1'b1;
  logic       berr_in_n = 1'b1;
  logic       halt_in_n = 1'b1;
  logic       as_n, term_stb, step_hold;
  logic [1:0] term_code;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  bus_term_ctrl u_dut (
    .clk(clk), .rst(rst), .cyc_req(cyc_req), .tmo_limit(tmo_limit),
    .dsz_ack_n(dsz_ack_n), .avec_ack_n(avec_ack_n), .berr_in_n(berr_in_n),
    .halt_in_n(halt_in_n), .as_n(as_n), .term_stb(term_stb),
    .term_code(term_code), .step_hold(step_hold)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic release_all();
    dsz_ack_n = 2'b11; avec_ack_n = 1'b1; berr_in_n = 1'b1; halt_in_n = 1'b1;
  endtask

  task automatic request();
    cyc_req = 1'b1; tick(); cyc_req = 1'b0;
  endtask

  task automatic wait_term(input int maxc, output bit got, output int code, output bit hold);
    got = 0; code = -1; hold = 0;
    for (int i = 0; i < maxc; i++) begin
      @(negedge clk);
      if (term_stb) begin
        got = 1; code = term_code; hold = step_hold;
        break;
      end
    end
    tick();
  endtask

  task automatic wait_strobe(input int maxc, output bit got);
    got = 0;
    for (int i = 0; i < maxc; i++) begin
      @(negedge clk);
      if (!as_n) begin got = 1; break; end
    end
    tick();
  endtask

  // ordering model: edge k sees each signal asserted from its first index on
  function automatic int model(input int a, input int b, input int h);
    for (int k = 1; k < 40; k++) begin
      bit av = (k >= a);
      bit bv = (b >= 0) && (k >= b);
      bit hv = (h >= 0) && (k >= h);
      if (bv) return hv ? 3 : 2;
      if (av) begin
        bit b1 = (b >= 0) && (k + 1 >= b);
        bit h1 = (h >= 0) && (k + 1 >= h);
        if (hv) return 1;
        if (b1) return h1 ? 3 : 2;
        return 0;
      end
    end
    return -1;
  endfunction

  task automatic finish_normal(input string req);
    bit got, hold; int code;
    dsz_ack_n = 2'b10;
    wait_term(10, got, code, hold);
    check(got && code == 0, req, code, 0);
    release_all(); tick(); tick();
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : main
    bit got, hold; int code, exp, cnt;
    repeat (3) tick();
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    check(as_n == 1 && term_stb == 0 && step_hold == 0, "R10", {as_n, term_stb, step_hold}, 3'b100);
    tick();

    // ordering sweep: R1 R2 R3 R4, monitor off
    tmo_limit = 8'd0;
    for (int a = 1; a <= 3; a++)
      for (int b = -1; b <= 5; b++)
        for (int h = -1; h <= 5; h++) begin
          if (b == 0) continue;
          exp = model(a, b, h);
          if (h == 0) halt_in_n = 1'b0;
          request();
          got = 0; code = -1; hold = 0;
          for (int k = 1; k <= 25; k++) begin
            dsz_ack_n = (k >= a) ? 2'b01 : 2'b11;
            berr_in_n = (b >= 0 && k >= b) ? 1'b0 : 1'b1;
            halt_in_n = (h >= 0 && k >= h) ? 1'b0 : 1'b1;
            @(negedge clk);
            if (term_stb) begin got = 1; code = term_code; hold = step_hold; break; end
            tick();
          end
          tick();
          release_all();
          check(got && code == exp, exp == 0 ? "R1" : exp == 1 ? "R2" : exp == 2 ? "R3" : "R4", code, exp);
          if (exp == 1) check(hold == 1, "R2 step flag", hold, 1);
          if (exp == 3) begin
            wait_strobe(10, got);
            check(got, "R4 reissue", got, 1);
            finish_normal("R4 reissued cycle");
          end else begin
            repeat (3) tick();
          end
        end

    // R5 timeout latency sweep
    for (int n = 1; n <= 12; n++) begin
      tmo_limit = 8'(n);
      request();
      @(negedge clk);
      check(as_n == 0, "R5 strobe", as_n, 0);
      cnt = 0; code = -1;
      for (int i = 0; i < 40; i++) begin
        @(negedge clk); cnt++;
        if (term_stb) begin code = term_code; break; end
      end
      check(cnt == n + 1 && code == 2, "R5", cnt, n + 1);
      tick(); tick();
    end

    // R6 limit zero disables timeout
    tmo_limit = 8'd0;
    request();
    wait_term(40, got, code, hold);
    check(!got, "R6 disabled", got, 0);
    finish_normal("R6 disabled end");

    // R6 and R9: autovector cancels a running timeout
    tmo_limit = 8'd3;
    request();
    tick();
    avec_ack_n = 1'b0;
    wait_term(10, got, code, hold);
    check(got && code == 0, "R9 autovector", code, 0);
    release_all();
    wait_term(10, got, code, hold);
    check(!got, "R6 cancelled", got, 0);

    // R8 stale acknowledge blocks the next start
    tmo_limit = 8'd0;
    request();
    dsz_ack_n = 2'b10;
    wait_term(10, got, code, hold);
    check(got && code == 0, "R1 directed", code, 0);
    request();
    cnt = 0;
    for (int i = 0; i < 5; i++) begin @(negedge clk); if (!as_n) cnt++; end
    check(cnt == 0, "R8 held off", cnt, 0);
    tick();
    release_all();
    wait_strobe(4, got);
    check(got, "R8 start after release", got, 1);
    finish_normal("R8 end");

    // R2 halt hold keeps the bus idle
    request();
    halt_in_n = 1'b0; tick(); dsz_ack_n = 2'b01;
    wait_term(10, got, code, hold);
    check(got && code == 1, "R2 directed", code, 1);
    dsz_ack_n = 2'b11;
    request();
    cnt = 0;
    for (int i = 0; i < 6; i++) begin @(negedge clk); if (!as_n || !step_hold) cnt++; end
    check(cnt == 0, "R2 hold", cnt, 0);
    tick();
    halt_in_n = 1'b1;
    wait_strobe(5, got);
    check(got && step_hold == 0, "R2 resume", got, 1);
    finish_normal("R2 end");

    // R7 strobe lasts one clock
    request();
    dsz_ack_n = 2'b01;
    cnt = 0;
    for (int i = 0; i < 8; i++) begin @(negedge clk); if (term_stb) cnt++; end
    check(cnt == 1, "R7", cnt, 1);
    tick(); release_all(); tick();

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule